// File: doc/BRIEF.md
# Segment Translation Unit

This block turns a two-part logical address into a physical address. The two parts are a segment number and a byte offset inside that segment. The segment descriptors sit in ordinary memory as a table. The table's start address and its entry count come in as inputs, and software keeps them current. For each accepted request the unit first compares the segment number against the entry count. If that passes, it fetches the descriptor's base word and then its limit word over a simple read port. It then compares the offset against the limit. The result is either the base plus the offset or a trap with a cause code.

The CPU side uses a valid/ready request and a single-cycle response strobe. Only one translation is in flight at a time. The memory side holds a read request with a stable address until the memory answers with a data-valid strobe, so table memory of any latency can be attached.

Top module: `seg_xlate`

## Requirements
- R1: During and just after reset, reqReady is 1, respValid is 0 and memReq is 0.
- R2: A request is taken only on a clock edge where reqValid and reqReady are both 1. reqReady drops in the next cycle, and any reqValid seen while busy has no effect on the response or on the table reads.
- R3: A translation of segment s makes exactly two table reads, in this order: the base word at tblBase + 8*s, then the limit word at tblBase + 8*s + 4. tblBase is sampled when the request is taken, so later changes to it have no effect on that translation.
- R4: If the segment number, unsigned, is greater than or equal to tblLen, the response carries cause 2'b01. No table read is made, and respValid rises in the cycle right after acceptance.
- R5: Once memReq rises, it stays high with memAddr unchanged until the cycle in which memRvalid is 1.
- R6: An offset greater than or equal to the fetched limit yields cause 2'b10. An offset equal to limit minus one translates normally.
- R7: A legal translation returns respTrap 0, cause 2'b00 and respAddr equal to base + offset modulo 2^ADDR_W.
- R8: Each accepted request produces exactly one respValid pulse, one cycle wide. After a legal translation with table latency L, that pulse comes 2L+3 cycles after acceptance. reqReady is 1 again in the cycle after the pulse.
- R9: In every response, respTrap is 1 exactly when the cause is non-zero, the cause is never 2'b11, and a trap response drives respAddr to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Unit idle, request will be taken |
| reqSeg | input | SEG_W | Segment number of the logical address |
| reqOff | input | ADDR_W | Offset within the segment |
| tblBase | input | ADDR_W | Byte address of the segment table |
| tblLen | input | SEG_W+1 | Number of valid table entries |
| memReq | output | 1 | Table read request, held until answered |
| memAddr | output | ADDR_W | Byte address of the table word being read |
| memRvalid | input | 1 | Table read data valid this cycle |
| memRdata | input | ADDR_W | Table read data |
| respValid | output | 1 | Response strobe, one cycle |
| respTrap | output | 1 | Translation failed |
| respCause | output | 2 | 00 none, 01 segment number out of range, 10 offset out of range |
| respAddr | output | ADDR_W | Physical address, zero on a trap |

## Verification
Several checks run on every cycle. The memory request is held with a stable address. A response pulse is one cycle wide and hands back readiness. The trap flag agrees with the cause code, and trap responses carry a zero address. An out-of-range segment number is answered the next cycle without a memory request. Some behaviour can only be shown by the bench's scenarios against its reference model. These are the exact table word addresses and their order, the added physical address including wrap-around, the offset boundary at the limit, response timing under different memory latencies, and the effect of poking the request or the table base while busy.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'b00,
    CAUSE_SEG  = 2'b01,
    CAUSE_OFF  = 2'b10
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;    // latch request fields and range verdict
    logic capBase;   // latch base word from memory
    logic capLim;    // latch limit word from memory
    logic limPhase;  // address the limit word of the entry
  } dpStrobe_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       segInRange,
  input  logic       memRvalid,
  output logic       reqReady,
  output logic       memReq,
  output logic       respValid,
  output dpStrobe_t  strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD_BASE, ST_RD_LIM, ST_RESP} state_e;
  state_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    reqReady  = 1'b0;
    memReq    = 1'b0;
    respValid = 1'b0;
    case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = segInRange ? ST_RD_BASE : ST_RESP;
        end
      end
      ST_RD_BASE: begin
        memReq = 1'b1;
        if (memRvalid) begin
          strobe.capBase = 1'b1;
          stateNext      = ST_RD_LIM;
        end
      end
      ST_RD_LIM: begin
        memReq          = 1'b1;
        strobe.limPhase = 1'b1;
        if (memRvalid) begin
          strobe.capLim = 1'b1;
          stateNext     = ST_RESP;
        end
      end
      default: begin
        respValid = 1'b1;
        stateNext = ST_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqOff,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [SEG_W:0]    tblLen,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              segInRange,
  output logic [ADDR_W-1:0] memAddr,
  output logic              respTrap,
  output logic [1:0]        respCause,
  output logic [ADDR_W-1:0] respAddr
);

  localparam int WORD_BYTES  = ADDR_W / 8;
  localparam int ENTRY_BYTES = 2 * WORD_BYTES;
  localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

  logic [SEG_W-1:0]  segR;
  logic [ADDR_W-1:0] offR, tblR, baseR, limR;
  logic              segBadR;

  assign segInRange = ({1'b0, reqSeg} < tblLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segR    <= '0;
      offR    <= '0;
      tblR    <= '0;
      baseR   <= '0;
      limR    <= '0;
      segBadR <= 1'b0;
    end else begin
      if (strobe.capReq) begin
        segR    <= reqSeg;
        offR    <= reqOff;
        tblR    <= tblBase;
        segBadR <= !segInRange;
      end
      if (strobe.capBase) baseR <= memRdata;
      if (strobe.capLim)  limR  <= memRdata;
    end
  end

  logic [ADDR_W-1:0] entryAddr;
  assign entryAddr = tblR + (ADDR_W'(segR) << ENTRY_SHIFT);
  assign memAddr   = entryAddr + (strobe.limPhase ? ADDR_W'(WORD_BYTES) : '0);

  always_comb begin
    if (segBadR) begin
      respTrap  = 1'b1;
      respCause = CAUSE_SEG;
      respAddr  = '0;
    end else if (offR >= limR) begin
      respTrap  = 1'b1;
      respCause = CAUSE_OFF;
      respAddr  = '0;
    end else begin
      respTrap  = 1'b0;
      respCause = CAUSE_NONE;
      respAddr  = baseR + offR;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W  = 8,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [SEG_W-1:0]  reqSeg,
  input  logic [ADDR_W-1:0] reqOff,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [SEG_W:0]    tblLen,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memRvalid,
  input  logic [ADDR_W-1:0] memRdata,
  output logic              respValid,
  output logic              respTrap,
  output logic [1:0]        respCause,
  output logic [ADDR_W-1:0] respAddr
);

  dpStrobe_t strobe;
  logic      segInRange;

  seg_xlate_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .segInRange (segInRange),
    .memRvalid  (memRvalid),
    .reqReady   (reqReady),
    .memReq     (memReq),
    .respValid  (respValid),
    .strobe     (strobe)
  );

  seg_xlate_dp #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .reqSeg     (reqSeg),
    .reqOff     (reqOff),
    .tblBase    (tblBase),
    .tblLen     (tblLen),
    .memRdata   (memRdata),
    .segInRange (segInRange),
    .memAddr    (memAddr),
    .respTrap   (respTrap),
    .respCause  (respCause),
    .respAddr   (respAddr)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W  = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [SEG_W-1:0]  reqSeg,
  input logic [SEG_W:0]    tblLen,
  input logic              memReq,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRvalid,
  input logic              respValid,
  input logic              respTrap,
  input logic [1:0]        respCause,
  input logic [ADDR_W-1:0] respAddr
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  a_r4_seg_trap_fast: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady && ({1'b0, reqSeg} >= tblLen)
      |=> respValid && respTrap && (respCause == 2'b01) && !memReq);

  a_r4_idle_no_read: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !memReq);

  a_r5_mem_hold: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memRvalid |=> memReq && $stable(memAddr));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid && reqReady);

  a_r9_cause_flag: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respTrap == (respCause != 2'b00)) && (respCause != 2'b11));

  a_r9_zero_on_trap: assert property (@(posedge clk) disable iff (!rstN)
    respValid && respTrap |-> respAddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqSeg    (reqSeg),
  .tblLen    (tblLen),
  .memReq    (memReq),
  .memAddr   (memAddr),
  .memRvalid (memRvalid),
  .respValid (respValid),
  .respTrap  (respTrap),
  .respCause (respCause),
  .respAddr  (respAddr)
);

// File: tb/sim_seg_xlate.sv
`timescale 1ns/1ps
module sim_seg_xlate;

  localparam int SEG_W  = 8;
  localparam int ADDR_W = 32;
  localparam int NSEG   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [SEG_W-1:0]  reqSeg = '0;
  logic [ADDR_W-1:0] reqOff = '0;
  logic [ADDR_W-1:0] tblBase = '0;
  logic [SEG_W:0]    tblLen = '0;
  logic              memReq;
  logic [ADDR_W-1:0] memAddr;
  logic              memRvalid = 1'b0;
  logic [ADDR_W-1:0] memRdata = '0;
  logic              respValid, respTrap;
  logic [1:0]        respCause;
  logic [ADDR_W-1:0] respAddr;

  always #2 clk = ~clk;

  seg_xlate #(.SEG_W(SEG_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqSeg(reqSeg), .reqOff(reqOff), .tblBase(tblBase), .tblLen(tblLen),
    .memReq(memReq), .memAddr(memAddr), .memRvalid(memRvalid), .memRdata(memRdata),
    .respValid(respValid), .respTrap(respTrap), .respCause(respCause), .respAddr(respAddr)
  );

  int nChecks = 0;
  int nFail   = 0;

  // reference table contents and its placement
  logic [31:0] baseT [NSEG];
  logic [31:0] limT  [NSEG];
  logic [31:0] tableAt = 32'h0000_4000;
  int          lenV    = 12;

  // memory model state
  int          memLat   = 0;
  int          waitCnt  = 0;
  int          reqCycles = 0;
  logic [31:0] logAddr [$];

  function automatic logic [31:0] lookup(logic [31:0] a);
    logic [31:0] rel;
    rel = a - tableAt;
    if (a >= tableAt && rel < NSEG * 8) begin
      if (rel[2]) return limT[rel >> 3];
      else        return baseT[rel >> 3];
    end
    return 32'hDEAD_BEEF;
  endfunction

  always @(negedge clk) begin
    if (memReq) begin
      reqCycles++;
      if (waitCnt >= memLat) begin
        memRvalid <= 1'b1;
        memRdata  <= lookup(memAddr);
        logAddr.push_back(memAddr);
        waitCnt = 0;
      end else begin
        memRvalid <= 1'b0;
        waitCnt++;
      end
    end else begin
      memRvalid <= 1'b0;
      waitCnt = 0;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one translation; called and returns at a falling edge
  task automatic doReq(int seg, logic [31:0] off, int lat, bit pokeBusy, bit moveBase);
    bit          expTrap;
    logic [1:0]  expCause;
    logic [31:0] expAddr;
    int          expReads, expCyc, cyc;
    if (seg >= lenV) begin
      expTrap = 1; expCause = 2'b01; expAddr = 0; expReads = 0; expCyc = 1;
    end else begin
      expReads = 2; expCyc = 2 * lat + 3;
      if (off >= limT[seg]) begin
        expTrap = 1; expCause = 2'b10; expAddr = 0;
      end else begin
        expTrap = 0; expCause = 2'b00; expAddr = baseT[seg] + off;
      end
    end
    memLat = lat;
    logAddr.delete();
    reqCycles = 0;
    reqValid = 1'b1;
    reqSeg   = SEG_W'(seg);
    reqOff   = off;
    @(negedge clk);
    chk(reqReady == 1'b0, "R2 busy after accept", 32'(reqReady), 32'd0);
    if (pokeBusy) begin
      reqSeg = SEG_W'((seg + 1) % lenV);
      reqOff = 32'h0;
    end else begin
      reqValid = 1'b0;
    end
    if (moveBase) tblBase = 32'h0008_0000;
    cyc = 1;
    while (!respValid && cyc < 60) begin
      @(negedge clk);
      cyc++;
      if (cyc == 2) reqValid = 1'b0;
    end
    chk(cyc == expCyc, "R8 R4 response latency", 32'(cyc), 32'(expCyc));
    chk(respTrap == expTrap, "R9 trap flag", 32'(respTrap), 32'(expTrap));
    chk(respCause == expCause, "R4 R6 R7 cause", 32'(respCause), 32'(expCause));
    chk(respAddr == expAddr, "R7 R9 address", respAddr, expAddr);
    chk(logAddr.size() == expReads, "R3 read count", 32'(logAddr.size()), 32'(expReads));
    if (expReads == 0)
      chk(reqCycles == 0, "R4 no table read", 32'(reqCycles), 32'd0);
    if (expReads == 2 && logAddr.size() == 2) begin
      chk(logAddr[0] == tableAt + 32'(seg) * 8, "R3 base word address", logAddr[0], tableAt + 32'(seg) * 8);
      chk(logAddr[1] == tableAt + 32'(seg) * 8 + 4, "R3 limit word address", logAddr[1], tableAt + 32'(seg) * 8 + 4);
    end
    @(negedge clk);
    chk(respValid == 1'b0, "R8 single pulse", 32'(respValid), 32'd0);
    chk(reqReady == 1'b1, "R8 ready again", 32'(reqReady), 32'd1);
    tblBase = tableAt;
  endtask

  initial begin
    for (int i = 0; i < NSEG; i++) begin
      baseT[i] = 32'h1000_0000 + 32'(i) * 32'h0001_0000;
      limT[i]  = 32'h100 + 32'(i) * 16;
    end
    baseT[7] = 32'hFFFF_FFF0;
    limT[7]  = 32'h1000;
    tblBase = tableAt;
    tblLen  = (SEG_W+1)'(lenV);
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1 ready in reset", 32'(reqReady), 32'd1);
    chk(respValid == 1'b0, "R1 no response in reset", 32'(respValid), 32'd0);
    chk(memReq == 1'b0, "R1 no read in reset", 32'(memReq), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && memReq == 1'b0, "R1 idle after reset", 32'(reqReady), 32'd1);

    doReq(2, 32'h10, 0, 0, 0);                 // R7 basic
    doReq(5, limT[5] - 1, 2, 0, 0);            // R6 last legal offset
    doReq(5, limT[5], 1, 0, 0);                // R6 offset equal to limit
    doReq(3, 32'hFFFF_FFFF, 0, 0, 0);          // R6 far beyond limit
    doReq(lenV, 32'h0, 0, 0, 0);               // R4 equal to length
    doReq(200, 32'h4, 3, 0, 0);                // R4 far out of range
    doReq(lenV - 1, 32'h20, 4, 0, 0);          // R4 last legal segment
    doReq(7, 32'h20, 1, 0, 0);                 // R7 wrap-around add
    doReq(4, 32'h30, 2, 1, 0);                 // R2 request while busy ignored
    doReq(6, 32'h8, 1, 0, 1);                  // R3 table base moved while busy
    doReq(0, 32'h0, 0, 0, 0);                  // R7 segment zero, offset zero
    lenV = 0;
    tblLen = '0;
    doReq(0, 32'h0, 0, 0, 0);                  // R4 empty table
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 4);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule